// File: doc/BRIEF.md
# Periodic Tick Timer with Register Port

This block is a down-counting periodic timer of the kind a processor core uses for its operating-system heartbeat. Software programs a reload value, picks a step source and sets the enable bit. The counter then walks down from the reload value to zero and starts over, so each period spans reload+1 steps. A step is either every core clock or every cycle in which an external reference tick enable is high.

Every time the count passes from one to zero, the block sets a sticky expiry flag. If interrupts are enabled, it also sends a single-cycle pending request to the interrupt controller. The flag clears when software reads the control word. Any write to the current-value register restarts the period and clears the flag. A reload value of zero at expiry turns the timer off.

All registers are 32-bit words on a simple memory-mapped port. Reads are combinational and writes take effect at the clock edge. The calibration word is a constant supplied at an input.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word, the reload value, the counter, the expiry flag and the interrupt output are all zero.
- R2: The register offsets are fixed. Control/status is at byte offset 0x10, reload at 0x14, current value at 0x18 and calibration at 0x1C. In the control word, bit 0 is enable, bit 1 is interrupt enable, bit 2 is step source and bit 16 is the expiry flag. A write changes only bits [2:0], and the flag cannot be written.
- R3: The reload register holds 24 bits. Read bits [31:24] return zero, and writes to them are dropped.
- R4: While enabled, a step on a counter at zero loads the reload value, and any other step decrements it. The current value therefore reads R, R-1, ..., 0 and repeats every R+1 steps.
- R5: When step source is 1, every clock is a step. When it is 0, only cycles with the reference tick enable high are steps.
- R6: The expiry flag sets on the step that takes the counter from 1 to 0. A read of the control word returns the flag and clears it.
- R7: On expiry with interrupt enable set, the interrupt output is high for exactly the following cycle. With interrupt enable clear, it stays low.
- R8: If the reload value is zero at expiry, the enable bit clears by itself, unless the control word is written in that same cycle.
- R9: A write of any data to the current-value register sets the counter to zero and clears the flag. The next step then loads the reload value.
- R10: The current value reads zero while the timer is disabled.
- R11: The calibration offset returns the calibration input. Unmapped offsets read zero and ignore writes.
- R12: When the enable bit is set with the counter at zero, the first step loads the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_en | input | 1 | External reference step enable, used when step source is 0 |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| calib_word | input | 32 | Constant calibration value |
| tick_irq | output | 1 | One-cycle pending request toward the interrupt controller |

## Verification
The bench sweeps small reload values with both step sources and several reference tick spacings, and predicts every current-value sample from the step count. An off-by-one period would drift against the prediction within a few periods, and a missing reload-at-zero step would skip the zero reading. The flag is read twice after each run: a design that does not clear it on read, or never sets it, fails one of the two reads. Dedicated sequences cover the self-disable on a zero reload written mid-count, the restart caused by writing the current value (the counter must read zero, then the reload value), zero reads while disabled, and the width masking on the reload and control writes.

// File: rtl/tick_timer_pkg.sv
// Package: shared constants and types for the periodic tick timer.
// Assumes byte addressing with word-aligned register offsets.
package tick_timer_pkg;

    // Register byte offsets (fixed; decoded by neighbouring software)
    localparam int unsigned OFS_CTRL   = 32'h10;
    localparam int unsigned OFS_RELOAD = 32'h14;
    localparam int unsigned OFS_CUR    = 32'h18;
    localparam int unsigned OFS_CALIB  = 32'h1C;

    // Control/status bit positions
    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_IRQEN  = 1;
    localparam int unsigned BIT_SRC    = 2;
    localparam int unsigned BIT_FLAG   = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CUR,
        SEL_CALIB
    } reg_sel_e;

    typedef struct packed {
        logic src;
        logic irq_en;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tick_addr_decode.sv
// Module: maps a byte offset to a register select.
// Assumes only exact, word-aligned offsets hit a register; all others select none.
module tick_addr_decode
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Exact compare against each register offset
    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
        else if (addr == ADDR_W'(OFS_CUR))    sel = SEL_CUR;
        else if (addr == ADDR_W'(OFS_CALIB))  sel = SEL_CALIB;
        else                                  sel = SEL_NONE;
    end

endmodule

// File: rtl/tick_step_gen.sv
// Module: produces the counting step qualifier.
// Assumes the reference tick enable is already synchronous to clk.
module tick_step_gen (
    input  logic en,
    input  logic src_core,
    input  logic ref_tick_en,
    output logic step
);

    // A step happens each clock on the core source, else on reference ticks
    always_comb begin
        step = en && (src_core || ref_tick_en);
    end

endmodule

// File: rtl/tick_down_counter.sv
// Module: down counter with reload at zero and a restart input.
// Assumes restart has priority over counting; expiry is the 1-to-0 step.
module tick_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: a real step moving the counter from one to zero
    always_comb begin
        expire = step && !restart && (cnt_q == ONE);
    end

    // Counter register: restart to zero, reload at zero, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - ONE;
        end
    end

    assign count = cnt_q;

    // R9: a restart leaves the counter at zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R4: without a step or restart the count holds
    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(cnt_q));

    // R4: an expiry always leaves the counter at zero
    a_r4_expire_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/tick_ctrl_regs.sv
// Module: control bits, expiry flag, reload register, interrupt pulse and read mux.
// Assumes a combinational read; read side effects land on the clock edge of the access.
module tick_ctrl_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] calib,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              restart,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);

    logic ctrl_wr, reload_wr, ctrl_rd, rd;
    logic flag_q, irq_q;
    ctrl_t ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [DATA_W-1:0] ctrl_word;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    // Access strobes per register
    always_comb begin
        rd        = valid && !we;
        ctrl_wr   = valid && we && (sel == SEL_CTRL);
        reload_wr = valid && we && (sel == SEL_RELOAD);
        restart   = valid && we && (sel == SEL_CUR);
        ctrl_rd   = rd && (sel == SEL_CTRL);
    end

    // Control bits: software write wins, else self-disable on zero reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.en     <= wdata[BIT_EN];
            ctrl_q.irq_en <= wdata[BIT_IRQEN];
            ctrl_q.src    <= wdata[BIT_SRC];
        end else if (expire && (reload_q == '0)) begin
            ctrl_q.en <= 1'b0;
        end
    end

    // Reload register: keeps only the counter-width low bits
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_wr) reload_q <= wdata[CNT_W-1:0];
    end

    // Expiry flag: set wins; cleared by control read or current-value write
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (expire)            flag_q <= 1'b1;
        else if (ctrl_rd || restart) flag_q <= 1'b0;
    end

    // Interrupt request: one cycle after an expiry with interrupts on
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && ctrl_q.irq_en;
    end

    // Control/status word assembly
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[BIT_EN]    = ctrl_q.en;
        ctrl_word[BIT_IRQEN] = ctrl_q.irq_en;
        ctrl_word[BIT_SRC]   = ctrl_q.src;
        ctrl_word[BIT_FLAG]  = flag_q;
    end

    // Read data multiplexer; zero when no read is in progress
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CTRL:   rdata = ctrl_word;
                SEL_RELOAD: rdata = DATA_W'(reload_q);
                SEL_CUR:    rdata = ctrl_q.en ? DATA_W'(count) : '0;
                SEL_CALIB:  rdata = calib;
                default:    rdata = '0;
            endcase
        end
    end

    assign ctrl       = ctrl_q;
    assign reload_val = reload_q;
    assign irq        = irq_q;

    // R7: the interrupt request never lasts more than one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6: an interrupt request is always accompanied by the set flag
    a_r6_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);

    // R8: zero reload at expiry turns the timer off
    a_r8_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (reload_q == '0) && !ctrl_wr) |=> !ctrl_q.en);

    // R3: the reload readback has its upper bits clear
    a_r3_reload_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == SEL_RELOAD)) |-> (rdata[DATA_W-1:CNT_W] == '0));

    // R10: current value reads zero while disabled
    a_r10_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == SEL_CUR) && !ctrl_q.en) |-> (rdata == '0));

    // R9: a current-value write leaves the flag clear unless it is set again
    a_r9_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag_q);

endmodule

// File: rtl/tick_timer.sv
// Module: top of the periodic tick timer; wires decode, step, counter and registers.
// Assumes CNT_W < DATA_W and a single-cycle register port with combinational reads.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_en,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] calib_word,
    output logic              tick_irq
);

    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic             step, expire, restart;
    logic [CNT_W-1:0] count, reload_val;

    tick_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    tick_step_gen u_step (
        .en          (ctrl.en),
        .src_core    (ctrl.src),
        .ref_tick_en (ref_tick_en),
        .step        (step)
    );

    tick_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .restart    (restart),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    tick_ctrl_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (reg_valid),
        .we         (reg_we),
        .sel        (sel),
        .wdata      (reg_wdata),
        .calib      (calib_word),
        .count      (count),
        .expire     (expire),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .restart    (restart),
        .irq        (tick_irq),
        .rdata      (reg_rdata)
    );

    // R5: with the reference source chosen, no step happens without a reference tick
    a_r5_ref_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.src && !ref_tick_en) |-> !step);

endmodule

// File: tb/test_tick_timer.sv
// Bench: sweeps reload values and step sources, predicting counts arithmetically.
module test_tick_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'h010;
    localparam logic [11:0] A_RLD  = 12'h014;
    localparam logic [11:0] A_CUR  = 12'h018;
    localparam logic [11:0] A_CAL  = 12'h01C;
    localparam logic [31:0] CALIB  = 32'h4000_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_en = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer i_tick_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick_en (ref_tick_en),
        .reg_valid   (reg_valid),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .calib_word  (CALIB),
        .tick_irq    (tick_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_valid = 1'b0;
    endtask

    // Expected current value after s steps from an enable with counter zero
    function automatic logic [31:0] exp_count(input int s, input int r);
        if (s == 0) return 32'd0;
        return 32'(r - ((s - 1) % (r + 1)));
    endfunction

    // One run: restart, enable, sample the current value every cycle, then check the flag
    task automatic run_window(input int r, input bit src, input bit irq_en,
                              input int ncyc, input int div);
        int s = 0;
        bit last_step = 1'b0;
        logic [31:0] rd;
        logic [31:0] ev;
        bit fired;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_RLD, 32'(r));
        bus_write(A_CUR, 32'hFFFF_FFFF);
        bus_write(A_CTRL, {29'd0, src, irq_en, 1'b1});
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            ref_tick_en = src ? 1'b0 : ((i % div) == 0);
            reg_valid = 1'b1; reg_we = 1'b0; reg_addr = A_CUR;
            #1;
            ev = exp_count(s, r);
            if (s == 1) check("R12 first step loads reload", reg_rdata, ev);
            else if (src) check("R4 count sequence", reg_rdata, ev);
            else check("R5 reference-step count", reg_rdata, ev);
            check("R7 irq pulse", {31'd0, tick_irq},
                  {31'd0, irq_en && last_step && (s >= 1) && (ev == 0)});
            @(posedge clk);
            if (src || ref_tick_en) begin s++; last_step = 1'b1; end
            else last_step = 1'b0;
        end
        #1 reg_valid = 1'b0;
        @(negedge clk); ref_tick_en = 1'b0;
        // the disabling write edge still counts as a step on the core source
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = A_CTRL;
        reg_wdata = {29'd0, src, irq_en, 1'b0};
        @(posedge clk);
        if (src) s++;
        #1 reg_valid = 1'b0; reg_we = 1'b0;
        fired = (s >= r + 1);
        bus_read(A_CTRL, rd);
        check("R6 flag after run", rd, {15'd0, fired, 13'd0, src, irq_en, 1'b0});
        bus_read(A_CTRL, rd);
        check("R6 flag cleared by read", rd, {29'd0, src, irq_en, 1'b0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", {31'd0, tick_irq}, 32'd0);
        bus_read(A_CTRL, rd); check("R1 control after reset", rd, 32'd0);
        bus_read(A_RLD, rd);  check("R1 reload after reset", rd, 32'd0);
        bus_read(A_CUR, rd);  check("R1 current after reset", rd, 32'd0);

        // R2 write mask on control, flag not writable
        bus_write(A_CTRL, 32'hFFFF_FFF8);
        bus_read(A_CTRL, rd); check("R2 upper control bits ignored", rd, 32'd0);
        bus_write(A_CTRL, 32'h0001_0006);
        bus_read(A_CTRL, rd); check("R2 flag not writable", rd, 32'h0000_0006);
        bus_write(A_CTRL, 32'h0);

        // R3 reload width
        bus_write(A_RLD, 32'hABCD_EF12);
        bus_read(A_RLD, rd); check("R3 reload upper bits", rd, 32'h00CD_EF12);

        // R11 calibration and unmapped offsets
        bus_read(A_CAL, rd); check("R11 calibration", rd, CALIB);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h020, rd); check("R11 unmapped reads zero", rd, 32'd0);
        bus_read(12'h012, rd); check("R11 unaligned reads zero", rd, 32'd0);
        bus_read(A_CTRL, rd); check("R11 unmapped write ignored", rd, 32'd0);

        // R4 R5 R6 R7 R12 sweeps
        for (int r = 1; r <= 6; r++)
            run_window(r, 1'b1, r[0], 3 * (r + 1) + 2, 1);
        for (int r = 1; r <= 4; r++)
            for (int d = 2; d <= 3; d++)
                run_window(r, 1'b0, 1'b1, d * (2 * (r + 1) + 1), d);

        // R8 zero reload written mid-count disables after the expiry
        bus_write(A_RLD, 32'd2);
        bus_write(A_CUR, 32'd0);
        bus_write(A_CTRL, 32'h7);
        bus_write(A_RLD, 32'd0);          // counter loads 2 on this edge
        @(negedge clk); check("R8 no irq at count 2", {31'd0, tick_irq}, 32'd0);
        @(negedge clk); check("R8 no irq at count 1", {31'd0, tick_irq}, 32'd0);
        @(posedge clk);
        bus_read(A_CTRL, rd);
        check("R8 enable cleared, flag set", rd, 32'h0001_0006);
        bus_read(A_CTRL, rd);
        check("R8 stays disabled", rd, 32'h0000_0006);
        bus_read(A_CUR, rd);  check("R10 disabled reads zero", rd, 32'd0);

        // R9 write to current restarts and clears the flag
        bus_write(A_RLD, 32'd5);
        bus_write(A_CTRL, 32'h7);
        repeat (9) @(posedge clk);
        bus_write(A_CUR, 32'hDEAD_BEEF);
        bus_read(A_CUR, rd); check("R9 current zero after write", rd, 32'd0);
        bus_read(A_CUR, rd); check("R9 next step loads reload", rd, 32'd5);
        bus_read(A_CTRL, rd); check("R9 flag cleared", rd, 32'h0000_0007);

        // R10 mid-count disable reads zero
        bus_write(A_CTRL, 32'h6);
        bus_read(A_CUR, rd); check("R10 mid-count disabled reads zero", rd, 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule